// File: doc/BRIEF.md
# Event-Framed Rate-Matching Buffer

This block sits between a fast word-parallel link receiver and a slower byte-serial transmitter. Words arrive in the write clock domain, 16 or 20 bits wide. They are written into a dual-clock FIFO together with one extra flag bit that closes an event. The FIFO is drained in the read clock domain whenever the transmitter is ready. When the word that closes an event leaves the buffer, an end-of-transmission strobe is raised with it.

The end of an event is found in one of two ways. The sender can raise an explicit marker with the last word. Otherwise the block compares each incoming word against a programmable boundary value, for sources that frame events with an in-band data pattern instead of a control symbol. There is no flow control toward the sender. The buffer has to be deep enough for the event backlog. If input stops, it empties by itself. An empty flag is exported for event-monitoring logic.

When the buffer is nearly full, one slot is held back so that a stored event is never left unterminated. Any word that is refused sets a sticky overflow flag.

Top module: `evbuf`

## Requirements
- R1: After reset, `empty` is 1, `out_valid` is 0, `out_eot` is 0 and `overflow` is 0.
- R2: Accepted words leave on `out_data` in arrival order with their value unchanged. In wide mode (`narrow`=0) all 20 bits are kept.
- R3: A word written with `in_last`=1 leaves with `out_eot`=1. `out_eot` is only ever 1 together with `out_valid`.
- R4: When `match_en`=1, a word whose (masked) value equals the (masked) `match_val` is flagged as end of event, just as `in_last` would flag it. When `match_en`=0, no value match flags a word.
- R5: In narrow mode (`narrow`=1), bits 19..16 of each stored word are forced to 0, and the boundary compare uses bits 15..0 only.
- R6: While DEPTH-1 words are held, a word that does not end an event is refused and a word that ends an event is accepted. While DEPTH words are held, every word is refused.
- R7: `overflow` becomes 1 on the first refused word and stays 1 until reset, including after the buffer drains.
- R8: While `tx_ready`=0, no word is emitted. With `tx_ready`=1 and no input, the buffer drains completely and `empty` returns to 1.
- R9: Each read-clock cycle with `tx_ready`=1 and `empty`=0 emits exactly one word on `out_valid` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side active-low synchronous reset |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side active-low synchronous reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Explicit end-of-event marker for this word |
| narrow | input | 1 | 1: 16-bit words, 0: full width |
| match_en | input | 1 | Enable boundary detection by data value |
| match_val | input | DATA_W | Boundary data value |
| overflow | output | 1 | Sticky flag: a word was refused |
| tx_ready | input | 1 | Transmitter can take a word |
| out_valid | output | 1 | Word present on out_data |
| out_data | output | DATA_W | Output word |
| out_eot | output | 1 | Output word ends an event |
| empty | output | 1 | Buffer holds no word (read-side view) |

## Verification
The case where two functions meet in one write cycle is the guard-slot decision against end-of-event detection. `tx_ready` is held low until exactly one slot remains. A non-final word is then offered, followed by a final word and one more final word. The drained stream must hold exactly DEPTH words, and only the last of them may carry `out_eot`. `overflow` must have risen and must still be 1 after the drain.

// File: rtl/evbuf_pkg.sv
`timescale 1ns/1ps
package evbuf_pkg;
    typedef enum logic {
        WIDTH_FULL   = 1'b0,
        WIDTH_NARROW = 1'b1
    } width_mode_e;

    localparam int NARROW_W = 16;
endpackage

// File: rtl/evbuf_sync.sv
`timescale 1ns/1ps
module evbuf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/evbuf_wside.sv
`timescale 1ns/1ps
module evbuf_wside
    import evbuf_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              narrow,
    input  logic              match_en,
    input  logic [DATA_W-1:0] match_val,
    input  logic [AW:0]       rgray_s,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W:0]   mem_wdata,
    output logic [AW:0]       wgray,
    output logic              overflow
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] LIM_FULL  = (AW+1)'(DEPTH);
    localparam logic [AW:0] LIM_GUARD = (AW+1)'(DEPTH - 1);
    localparam logic [DATA_W-1:0] NARROW_MASK =
        (DATA_W > NARROW_W) ? DATA_W'((64'd1 << NARROW_W) - 64'd1) : '1;

    typedef struct packed {
        logic [AW:0] wbin;
        logic [AW:0] wgray;
        logic        ovf;
    } wstate_t;

    wstate_t st_d, st_q;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [AW:0] from_gray(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [DATA_W-1:0] word_d, ref_d;
    logic [AW:0]       occ;
    logic              eoe_d, accept_d;

    always_comb begin
        if (width_mode_e'(narrow) == WIDTH_NARROW) begin
            word_d = in_data & NARROW_MASK;
            ref_d  = match_val & NARROW_MASK;
        end else begin
            word_d = in_data;
            ref_d  = match_val;
        end
        eoe_d    = in_last | (match_en & (word_d == ref_d));
        occ      = st_q.wbin - from_gray(rgray_s);
        accept_d = in_valid & ((occ < LIM_GUARD) | ((occ == LIM_GUARD) & eoe_d));

        st_d       = st_q;
        st_d.wbin  = st_q.wbin + (AW+1)'(accept_d);
        st_d.wgray = to_gray(st_d.wbin);
        st_d.ovf   = st_q.ovf | (in_valid & ~accept_d);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_we    = accept_d;
    assign mem_waddr = st_q.wbin[AW-1:0];
    assign mem_wdata = {eoe_d, word_d};
    assign wgray     = st_q.wgray;
    assign overflow  = st_q.ovf;

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= LIM_FULL);                                                  // R6
    AST_GUARD_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !eoe_d && occ >= LIM_GUARD) |=> $stable(wgray));      // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);                                            // R7
endmodule

// File: rtl/evbuf_rside.sv
`timescale 1ns/1ps
module evbuf_rside #(
    parameter int DATA_W = 20,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_ready,
    input  logic [AW:0]       wgray_s,
    input  logic [DATA_W:0]   mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [AW:0]       rgray,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eot,
    output logic              empty
);
    typedef struct packed {
        logic [AW:0]       rbin;
        logic [AW:0]       rgray;
        logic              vld;
        logic              eot;
        logic [DATA_W-1:0] data;
    } rstate_t;

    rstate_t st_d, st_q;
    logic    empty_d, pop_d;

    function automatic logic [AW:0] to_gray(input logic [AW:0] b);
        return b ^ (b >> 1);
    endfunction

    always_comb begin
        empty_d = (st_q.rgray == wgray_s);
        pop_d   = tx_ready & ~empty_d;

        st_d       = st_q;
        st_d.rbin  = st_q.rbin + (AW+1)'(pop_d);
        st_d.rgray = to_gray(st_d.rbin);
        st_d.vld   = pop_d;
        st_d.eot   = pop_d & mem_rdata[DATA_W];
        if (pop_d) st_d.data = mem_rdata[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_raddr = st_q.rbin[AW-1:0];
    assign rgray     = st_q.rgray;
    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
    assign out_eot   = st_q.eot;
    assign empty     = empty_d;

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready || empty) |=> !out_valid);                              // R8
    AST_EOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_eot |-> out_valid);                                            // R3
endmodule

// File: rtl/evbuf.sv
`timescale 1ns/1ps
module evbuf #(
    parameter int DATA_W = 20,
    parameter int AW     = 6
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              narrow,
    input  logic              match_en,
    input  logic [DATA_W-1:0] match_val,
    output logic              overflow,
    input  logic              tx_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eot,
    output logic              empty
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W:0] mem [DEPTH];
    logic            mem_we;
    logic [AW-1:0]   mem_waddr, mem_raddr;
    logic [DATA_W:0] mem_wdata, mem_rdata;
    logic [AW:0]     wgray, rgray, wgray_s, rgray_s;

    always_ff @(posedge wr_clk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
    end
    assign mem_rdata = mem[mem_raddr];

    evbuf_wside #(.DATA_W(DATA_W), .AW(AW)) u_wside (
        .clk(wr_clk), .rst_n(wr_rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .narrow(narrow), .match_en(match_en), .match_val(match_val),
        .rgray_s(rgray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .wgray(wgray), .overflow(overflow)
    );

    evbuf_rside #(.DATA_W(DATA_W), .AW(AW)) u_rside (
        .clk(rd_clk), .rst_n(rd_rst_n), .tx_ready(tx_ready),
        .wgray_s(wgray_s), .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
        .rgray(rgray), .out_valid(out_valid), .out_data(out_data),
        .out_eot(out_eot), .empty(empty)
    );

    evbuf_sync #(.W(AW+1)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s)
    );

    evbuf_sync #(.W(AW+1)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s)
    );
endmodule

// File: tb/evbuf_test.sv
`timescale 1ns/1ps
module evbuf_test;
    localparam int WR_PERIOD = 19;
    localparam int RD_PERIOD = 50;
    localparam int DATA_W    = 20;
    localparam int AW        = 6;
    localparam int DEPTH     = 1 << AW;

    logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
    logic in_valid = 0, in_last = 0, narrow = 0, match_en = 0, tx_ready = 0;
    logic [DATA_W-1:0] in_data = '0, match_val = '0;
    logic overflow, out_valid, out_eot, empty;
    logic [DATA_W-1:0] out_data;

    int n_checks = 0, n_fail = 0;
    logic [DATA_W:0] exp_q[$];
    logic [DATA_W:0] got_q[$];

    always #(WR_PERIOD/2.0) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2.0) rd_clk = ~rd_clk;

    evbuf #(.DATA_W(DATA_W), .AW(AW)) uut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .narrow(narrow), .match_en(match_en), .match_val(match_val),
        .overflow(overflow), .tx_ready(tx_ready), .out_valid(out_valid),
        .out_data(out_data), .out_eot(out_eot), .empty(empty)
    );

    always @(negedge rd_clk) begin
        if (rd_rst_n && out_valid) got_q.push_back({out_eot, out_data});
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W:0] model(input logic [DATA_W-1:0] d, input logic l);
        logic [DATA_W-1:0] w, r;
        w = narrow ? (d & 20'h0FFFF) : d;
        r = narrow ? (match_val & 20'h0FFFF) : match_val;
        return {l | (match_en & (w == r)), w};
    endfunction

    task automatic put(input logic [DATA_W-1:0] d, input logic l, input bit keep);
        in_valid = 1; in_data = d; in_last = l;
        if (keep) exp_q.push_back(model(d, l));
        @(negedge wr_clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic drain_check(input string req);
        tx_ready = 1;
        repeat (6) @(negedge rd_clk);
        for (int i = 0; i < 400 && !empty; i++) @(negedge rd_clk);
        repeat (4) @(negedge rd_clk);
        check({req, " empty after drain"}, 32'(empty), 32'd1);
        check({req, " word count"}, 32'(got_q.size()), 32'(exp_q.size()));
        for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
            check({req, " word"}, 32'(got_q[i]), 32'(exp_q[i]));
        exp_q.delete();
        got_q.delete();
    endtask

    task automatic t_reset;
        check("R1 empty", 32'(empty), 32'd1);
        check("R1 out_valid", 32'(out_valid), 32'd0);
        check("R1 out_eot", 32'(out_eot), 32'd0);
        check("R1 overflow", 32'(overflow), 32'd0);
    endtask

    task automatic t_wide_marker;
        narrow = 0; match_en = 0; match_val = 20'hABCDE;
        @(negedge wr_clk);
        put(20'hF0001, 0, 1);
        put(20'hABCDE, 0, 1);
        put(20'h80000, 0, 1);
        put(20'h12345, 1, 1);
        put(20'h00007, 1, 1);
        drain_check("R2/R3/R4 wide stream, marker, match off");
    endtask

    task automatic t_match;
        narrow = 0; match_en = 1; match_val = 20'hABCDE;
        @(negedge wr_clk);
        put(20'h11111, 0, 1);
        put(20'hABCDE, 0, 1);
        put(20'hABCDF, 0, 1);
        put(20'hABCDE, 0, 1);
        drain_check("R4 value match");
    endtask

    task automatic t_narrow;
        narrow = 1; match_en = 1; match_val = 20'h05555;
        @(negedge wr_clk);
        put(20'hF1234, 0, 1);
        put(20'hA5555, 0, 1);
        put(20'h35554, 1, 1);
        drain_check("R5 narrow mask and compare");
        narrow = 0; match_en = 0;
    endtask

    task automatic t_hold;
        int seen;
        tx_ready = 0;
        @(negedge wr_clk);
        put(20'h00A01, 0, 1);
        put(20'h00A02, 0, 1);
        put(20'h00A03, 1, 1);
        repeat (20) @(negedge rd_clk);
        seen = got_q.size();
        check("R8 no output while tx_ready low", 32'(seen), 32'd0);
        check("R8 not empty while held", 32'(empty), 32'd0);
        // one ready cycle: exactly one word next cycle
        tx_ready = 1;
        @(negedge rd_clk);
        tx_ready = 0;
        check("R9 one word after one ready cycle", 32'(out_valid), 32'd1);
        @(negedge rd_clk);
        check("R9 no second word", 32'(out_valid), 32'd0);
        drain_check("R8/R9 release drain");
    endtask

    task automatic t_guard;
        tx_ready = 0;
        repeat (4) @(negedge wr_clk);
        for (int i = 0; i < DEPTH - 1; i++) put(20'(32'h100 + i), 0, 1);
        check("R7 no overflow below guard", 32'(overflow), 32'd0);
        put(20'h0DEAD, 0, 0);
        check("R6 guard refuses non-final / R7 overflow set", 32'(overflow), 32'd1);
        put(20'h0BEEF, 1, 1);
        put(20'h0CAFE, 1, 0);
        drain_check("R6 guard slot");
        check("R7 overflow sticky after drain", 32'(overflow), 32'd1);
    endtask

    initial begin
        #(RD_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge rd_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        repeat (3) @(negedge rd_clk);
        t_reset;
        t_wide_marker;
        t_match;
        t_narrow;
        t_hold;
        t_guard;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule